// File: doc/BRIEF.md
# Timestamped Sample Packer with Retry

This block sits between an absolute-position sensor reader and a streaming FIFO that carries data to a host. Once a host-writable enable is set, a period timer starts a new acquisition at a fixed microsecond interval. Each acquisition asks the reader for a sample and waits for it. A sample flagged as implausible is thrown away and asked for again, up to a bounded number of times. The first plausible sample is stamped with the free-running microsecond count at the moment it is accepted. Timestamp and position then go out together as one 64-bit record, so the host can never pair a timestamp with the wrong position.

If the FIFO reports full when a record is ready, the record is dropped rather than held, and a drop counter counts it. A sequence that runs out of retries is abandoned and counted in an error counter. A period tick that arrives while a sequence is still busy is remembered and served as soon as that sequence ends.

Top module: `ts_sample_packer`

## Requirements
- R1: After reset, rd_req and fifo_wr are low, fifo_data is zero, and both drop_cnt and err_cnt read zero.
- R2: While acq_en is low, rd_req stays low and no acquisition starts.
- R3: While acq_en is high, a new acquisition begins every PERIOD_US microseconds. With prompt sensor replies, consecutive first requests are exactly PERIOD_US*CLK_PER_US clock cycles apart.
- R4: Each record is laid out as follows: bits 63:32 hold the timestamp, bits 23:0 hold the position, and bits 31:24 are zero.
- R5: The timestamp is the microsecond count on the clock edge that accepts the good reading. This count is the number of clock edges since reset divided by CLK_PER_US, truncated, modulo 2^32.
- R6: A reading with rd_ok low is not written, and rd_req is raised again in the cycle after that reading is taken.
- R7: After MAX_RETRY re-requests, one more implausible reading abandons the sample. err_cnt goes up by one, nothing is written, and no further request is made until the next period.
- R8: A good reading accepted while fifo_full is high produces no write, and drop_cnt goes up by one.
- R9: fifo_wr is high for exactly one cycle per written record, in the cycle after the accepting edge.
- R10: A period tick that occurs while a sequence is busy is kept. rd_req rises two cycles after the accepting edge of the busy sequence.
- R11: With saturation selected, drop_cnt and err_cnt stop at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Host enable for periodic acquisition |
| rd_req | output | 1 | One-cycle request for a new sensor reading |
| rd_valid | input | 1 | Reader strobe: a reading is present |
| rd_ok | input | 1 | Reading passed the plausibility check |
| rd_pos | input | POS_W (24) | Position value of the reading |
| fifo_full | input | 1 | Downstream FIFO has no room |
| fifo_wr | output | 1 | Write strobe for one record |
| fifo_data | output | 64 | Packed record: timestamp and position |
| drop_cnt | output | CNT_W (16) | Records dropped because the FIFO was full |
| err_cnt | output | CNT_W (16) | Samples abandoned after retries ran out |

## Verification
Two functions can land in the same cycle: the period tick and a sequence that is still waiting for a good reading. The bench provokes this by holding back the sensor reply for longer than one period, so the tick arrives while the sequencer is busy. It then requires that the held record is written, and that a fresh request follows exactly two cycles after the accepting edge rather than one period later. A second overlap occurs when a good reading and a full FIFO meet on the same edge. The bench judges this by checking that no write strobe appears and that the drop count steps by one, and it repeats the case until the count saturates.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int TS_W   = 32;
   localparam int HALF_W = 32;
   localparam int REC_W  = TS_W + HALF_W;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } acq_state_e;
endpackage

// File: rtl/tsp_timebase.sv
module tsp_timebase #(
   parameter int CLK_PER_US = 50,
   parameter int PERIOD_US  = 1000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   output logic [31:0] us_now,
   output logic        trig
);
   localparam int PRE_W = $clog2(CLK_PER_US + 1);
   localparam int PER_W = $clog2(PERIOD_US + 1);

   logic [PRE_W-1:0] pre_q;
   logic [PER_W-1:0] per_q;
   logic             us_tick;

   generate
      if (CLK_PER_US == 1) begin : g_no_pre
         assign us_tick = 1'b1;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pre_q <= '0;
            else        pre_q <= '0;
      end else begin : g_pre
         assign us_tick = (pre_q == PRE_W'(CLK_PER_US - 1));
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)       pre_q <= '0;
            else if (us_tick) pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       us_now <= '0;
      else if (us_tick) us_now <= us_now + 1'b1;

   assign trig = enable && us_tick && (per_q == PER_W'(PERIOD_US - 1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       per_q <= '0;
      else if (!enable) per_q <= '0;
      else if (us_tick) per_q <= (per_q == PER_W'(PERIOD_US - 1)) ? '0 : per_q + 1'b1;
endmodule

// File: rtl/tsp_evt_counter.sv
module tsp_evt_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   output logic [W-1:0] cnt
);
   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                  cnt <= '0;
            else if (evt && (cnt != '1)) cnt <= cnt + 1'b1;
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)   cnt <= '0;
            else if (evt) cnt <= cnt + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tsp_acq_seq.sv
module tsp_acq_seq
   import tsp_pkg::*;
#(
   parameter int POS_W     = 24,
   parameter int MAX_RETRY = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acq_en,
   input  logic             trig,
   input  logic             rd_valid,
   input  logic             rd_ok,
   input  logic [POS_W-1:0] rd_pos,
   input  logic [TS_W-1:0]  us_now,
   input  logic             fifo_full,
   output logic             rd_req,
   output logic             fifo_wr,
   output logic [REC_W-1:0] fifo_data,
   output logic             drop_evt,
   output logic             err_evt
);
   localparam int RT_W = $clog2(MAX_RETRY + 1);

   acq_state_e        state_q;
   logic [RT_W-1:0]   retry_q;
   logic              pend_q;
   logic              start;
   logic              take;
   logic              spent;
   logic [HALF_W-1:0] pos_ext;

   always_comb begin
      pos_ext = '0;
      pos_ext[POS_W-1:0] = rd_pos;
   end

   assign start    = acq_en && (trig || pend_q);
   assign take     = (state_q == ST_WAIT) && rd_valid;
   assign spent    = (retry_q == RT_W'(MAX_RETRY));
   assign rd_req   = (state_q == ST_REQ);
   assign drop_evt = take && rd_ok && fifo_full;
   assign err_evt  = take && !rd_ok && spent;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            pend_q <= 1'b0;
      else if (!acq_en)                      pend_q <= 1'b0;
      else if (trig && state_q != ST_IDLE)   pend_q <= 1'b1;
      else if (state_q == ST_IDLE && start)  pend_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         retry_q   <= '0;
         fifo_wr   <= 1'b0;
         fifo_data <= '0;
      end else begin
         fifo_wr <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_REQ;
               retry_q <= '0;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: if (rd_valid) begin
               if (rd_ok) begin
                  state_q <= ST_IDLE;
                  if (!fifo_full) begin
                     fifo_wr   <= 1'b1;
                     fifo_data <= {us_now, pos_ext};
                  end
               end else if (!spent) begin
                  retry_q <= retry_q + 1'b1;
                  state_q <= ST_REQ;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ts_sample_packer.sv
module ts_sample_packer
   import tsp_pkg::*;
#(
   parameter int CLK_PER_US = 50,
   parameter int PERIOD_US  = 1000,
   parameter int MAX_RETRY  = 8,
   parameter int POS_W      = 24,
   parameter int CNT_W      = 16,
   parameter bit CNT_SAT    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acq_en,
   output logic             rd_req,
   input  logic             rd_valid,
   input  logic             rd_ok,
   input  logic [POS_W-1:0] rd_pos,
   input  logic             fifo_full,
   output logic             fifo_wr,
   output logic [REC_W-1:0] fifo_data,
   output logic [CNT_W-1:0] drop_cnt,
   output logic [CNT_W-1:0] err_cnt
);
   generate
      if (CLK_PER_US < 1)               begin : g_bad_pre   $error("CLK_PER_US must be at least 1"); end
      if (PERIOD_US < 2)                begin : g_bad_per   $error("PERIOD_US must be at least 2"); end
      if (MAX_RETRY < 1)                begin : g_bad_rt    $error("MAX_RETRY must be at least 1"); end
      if (POS_W < 1 || POS_W > HALF_W)  begin : g_bad_pos   $error("POS_W must fit in one half record"); end
      if (CNT_W < 1)                    begin : g_bad_cnt   $error("CNT_W must be at least 1"); end
   endgenerate

   logic [TS_W-1:0] us_now;
   logic            trig;
   logic            drop_evt;
   logic            err_evt;

   tsp_timebase #(.CLK_PER_US(CLK_PER_US), .PERIOD_US(PERIOD_US)) u_time (
      .clk(clk), .rst_n(rst_n), .enable(acq_en), .us_now(us_now), .trig(trig)
   );

   tsp_acq_seq #(.POS_W(POS_W), .MAX_RETRY(MAX_RETRY)) u_seq (
      .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .trig(trig),
      .rd_valid(rd_valid), .rd_ok(rd_ok), .rd_pos(rd_pos), .us_now(us_now),
      .fifo_full(fifo_full), .rd_req(rd_req), .fifo_wr(fifo_wr),
      .fifo_data(fifo_data), .drop_evt(drop_evt), .err_evt(err_evt)
   );

   tsp_evt_counter #(.W(CNT_W), .SATURATE(CNT_SAT)) u_drop (
      .clk(clk), .rst_n(rst_n), .evt(drop_evt), .cnt(drop_cnt)
   );

   tsp_evt_counter #(.W(CNT_W), .SATURATE(CNT_SAT)) u_err (
      .clk(clk), .rst_n(rst_n), .evt(err_evt), .cnt(err_cnt)
   );
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic             fifo_full,
   input logic             fifo_wr,
   input logic [CNT_W-1:0] drop_cnt,
   input logic [CNT_W-1:0] err_cnt
);
   // R9: a write strobe never lasts two cycles
   a_r9_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |=> !fifo_wr);

   // R8: a write only follows an edge at which the FIFO had room
   a_r8_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> !$past(fifo_full));

   // R8: a written record is never also counted as dropped
   a_r8_write_not_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $stable(drop_cnt));

   // R8: the drop count only moves up by one
   a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == CNT_W'($past(drop_cnt) + 1'b1)));

   // R7: the error count only moves up by one
   a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt != $past(err_cnt)) |-> (err_cnt == CNT_W'($past(err_cnt) + 1'b1)));

   // R6: each request is a single-cycle pulse
   a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R7: an abandoned sample issues no request in the following cycle
   a_r7_no_req_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt != $past(err_cnt)) |-> !rd_req);
endmodule

bind ts_sample_packer tsp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .fifo_full(fifo_full),
   .fifo_wr(fifo_wr), .drop_cnt(drop_cnt), .err_cnt(err_cnt)
);

// File: tb/test_ts_sample_packer.sv
module test_ts_sample_packer;
   localparam int K   = 4;
   localparam int PER = 20;
   localparam int MR  = 3;
   localparam int CW  = 3;
   localparam int PW  = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acq_en = 1'b0;
   logic          rd_req;
   logic          rd_valid = 1'b0;
   logic          rd_ok = 1'b0;
   logic [PW-1:0] rd_pos = '0;
   logic          fifo_full = 1'b0;
   logic          fifo_wr;
   logic [63:0]   fifo_data;
   logic [CW-1:0] drop_cnt;
   logic [CW-1:0] err_cnt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [31:0] cyc;

   ts_sample_packer #(.CLK_PER_US(K), .PERIOD_US(PER), .MAX_RETRY(MR),
                      .POS_W(PW), .CNT_W(CW), .CNT_SAT(1'b1)) i_ts_sample_packer (
      .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_ok(rd_ok), .rd_pos(rd_pos), .fifo_full(fifo_full),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .drop_cnt(drop_cnt), .err_cnt(err_cnt)
   );

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_req(output int at);
      int n = 0;
      @(negedge clk);
      while (!rd_req && n < 400) begin
         @(negedge clk);
         n++;
      end
      if (!rd_req) check(1'b0, "R3 request timeout", 64'(rd_req), 64'd1);
      at = int'(cyc);
   endtask

   task automatic give(input bit ok, input logic [PW-1:0] pos, input int delay, output logic [31:0] ts);
      repeat (delay) @(negedge clk);
      rd_valid = 1'b1;
      rd_ok    = ok;
      rd_pos   = pos;
      ts       = cyc / K;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_ok    = 1'b0;
   endtask

   task automatic check_record(input logic [PW-1:0] pos, input logic [31:0] ts);
      check(fifo_wr === 1'b1, "R9 write strobe", 64'(fifo_wr), 64'd1);
      check(fifo_data[63:32] === ts, "R5 timestamp", 64'(fifo_data[63:32]), 64'(ts));
      check(fifo_data[31:0] === {8'h00, pos}, "R4 position field", 64'(fifo_data[31:0]), 64'({8'h00, pos}));
      @(negedge clk);
      check(fifo_wr === 1'b0, "R9 strobe one cycle", 64'(fifo_wr), 64'd0);
   endtask

   task automatic t_reset;
      check(rd_req === 1'b0 && fifo_wr === 1'b0, "R1 strobes low", {62'd0, rd_req, fifo_wr}, 64'd0);
      check(fifo_data === 64'd0, "R1 data zero", fifo_data, 64'd0);
      check(drop_cnt === '0 && err_cnt === '0, "R1 counters zero", 64'({drop_cnt, err_cnt}), 64'd0);
   endtask

   task automatic t_idle_window(input string tag);
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (rd_req) seen++;
      end
      check(seen == 0, tag, 64'(seen), 64'd0);
   endtask

   task automatic t_basic;
      int c1, c2;
      logic [31:0] ts;
      acq_en = 1'b1;
      wait_req(c1);
      give(1'b1, 24'hABCDEF, 1, ts);
      check_record(24'hABCDEF, ts);
      wait_req(c2);
      check(c2 - c1 == K * PER, "R3 period spacing", 64'(c2 - c1), 64'(K * PER));
      give(1'b1, 24'h000001, 1, ts);
      check_record(24'h000001, ts);
   endtask

   task automatic t_retry;
      int c;
      logic [31:0] ts;
      wait_req(c);
      give(1'b0, 24'h111111, 1, ts);
      check(fifo_wr === 1'b0, "R6 bad reading not written", 64'(fifo_wr), 64'd0);
      check(rd_req === 1'b1, "R6 re-request", 64'(rd_req), 64'd1);
      give(1'b1, 24'hFFFFFF, 1, ts);
      check_record(24'hFFFFFF, ts);
      check(err_cnt === '0, "R6 no error on recovery", 64'(err_cnt), 64'd0);
   endtask

   task automatic t_exhaust;
      int c, seen;
      logic [31:0] ts;
      wait_req(c);
      for (int i = 0; i < MR; i++) begin
         give(1'b0, 24'h222222, 1, ts);
         check(rd_req === 1'b1, "R7 retry within limit", 64'(rd_req), 64'd1);
      end
      give(1'b0, 24'h333333, 1, ts);
      check(rd_req === 1'b0 && fifo_wr === 1'b0, "R7 abandoned", {62'd0, rd_req, fifo_wr}, 64'd0);
      check(err_cnt === CW'(1), "R7 error counted", 64'(err_cnt), 64'd1);
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (rd_req) seen++;
      end
      check(seen == 0, "R7 quiet until next period", 64'(seen), 64'd0);
   endtask

   task automatic t_full;
      int c;
      logic [31:0] ts;
      wait_req(c);
      fifo_full = 1'b1;
      give(1'b1, 24'h444444, 1, ts);
      fifo_full = 1'b0;
      check(fifo_wr === 1'b0, "R8 no write when full", 64'(fifo_wr), 64'd0);
      check(drop_cnt === CW'(1), "R8 drop counted", 64'(drop_cnt), 64'd1);
   endtask

   task automatic t_pending;
      int c;
      logic [31:0] ts;
      wait_req(c);
      give(1'b1, 24'h555555, K * PER + 5, ts);
      check_record(24'h555555, ts);
      check(rd_req === 1'b1, "R10 held trigger served", 64'(rd_req), 64'd1);
      give(1'b1, 24'h666666, 1, ts);
      check_record(24'h666666, ts);
   endtask

   task automatic t_saturate;
      int c;
      logic [31:0] ts;
      fifo_full = 1'b1;
      for (int i = 0; i < 7; i++) begin
         wait_req(c);
         give(1'b1, 24'h777777, 1, ts);
      end
      fifo_full = 1'b0;
      check(drop_cnt === '1, "R11 drop count saturates", 64'(drop_cnt), 64'((1 << CW) - 1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_idle_window("R2 no request while disabled");
      t_basic;
      t_retry;
      t_exhaust;
      t_full;
      t_pending;
      t_saturate;
      @(negedge clk);
      acq_en = 1'b0;
      t_idle_window("R2 no request after disable");
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R3 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule